// File: doc/BRIEF.md
# SPI Register-Access Master

This block runs complete register transactions against SPI peripherals. One command holds a register number, a direction flag, a data byte count, a clock-phase choice and a target choice. For that command the block pulls one of two active-low chip selects, sends an address byte and then the data bytes, most significant bit first, and releases the select after the last byte. In a write, the data bytes come from a valid/ready input stream. In a read, the received bytes leave on a valid/ready output stream.

The address byte carries the direction in its top bit and the register number in the seven bits below it. A count above one makes a burst of consecutive registers, all under one chip-select assertion. The byte clocked in while the address goes out is kept and presented as a status value. SCK is made inside the block: a parameter sets how many system clocks each half period lasts.

If a stream is not ready, the block waits at the next byte boundary. During that wait SCK stays low and the chip select stays asserted.

Top module: `spi_reg_master`

## Requirements
- R1: During reset and whenever no transaction runs, both chip selects are high, SCK is low, MOSI is low and busy is low.
- R2: The first byte of a transaction is {write flag, register number}: bit 7 is 1 for a write and 0 for a read, and bits 6:0 carry `cmd_reg_i`.
- R3: `cmd_target_i`=0 drives `cs_n_o[0]` and `cmd_target_i`=1 drives `cs_n_o[1]`. The other select stays high, and two selects are never low at the same time.
- R4: A transaction shifts exactly 1+`cmd_len_i` bytes (count 0 to 255) inside a single chip-select assertion. Burst bytes go to or come from consecutive registers.
- R5: The byte received while the address byte is sent is held on `status_o` from the end of the address byte until the next transaction's address byte ends.
- R6: In the data bytes of a read, MOSI stays low.
- R7: Bits move MSB first. With phase 0, MOSI changes while SCK is low, and MISO is sampled at the end of the SCK high half.
- R8: With phase 1, MOSI changes at the rising SCK edge, and MISO is sampled at the end of the low half that follows the falling edge.
- R9: Every SCK high and low half inside a byte lasts exactly `HALF_CLKS` system clocks.
- R10: `busy_o` is high from command acceptance until the chip select is released, and `cmd_ready_o` is its inverse. A command presented while busy is not taken.
- R11: A write byte is taken through `wr_valid_i`/`wr_ready_o` before it is shifted. A read byte is held on `rd_data_o` with `rd_valid_o` until `rd_ready_i`. While either stream waits, no SCK edge occurs.
- R12: Phase and target are captured at acceptance. Changes on the command inputs during a transaction have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command taken on this clock when valid |
| cmd_write_i | input | 1 | 1 = write transaction, 0 = read |
| cmd_reg_i | input | DATA_W-1 | Start register number |
| cmd_len_i | input | LEN_W | Data byte count after the address |
| cmd_phase_i | input | 1 | Clock phase: 0 or 1 |
| cmd_target_i | input | 1 | Chip select choice |
| wr_valid_i | input | 1 | Write byte offered |
| wr_ready_o | output | 1 | Write byte taken when valid |
| wr_data_i | input | DATA_W | Write byte |
| rd_valid_o | output | 1 | Read byte present |
| rd_ready_i | input | 1 | Read byte consumed |
| rd_data_o | output | DATA_W | Read byte |
| status_o | output | DATA_W | Byte received during the address byte |
| busy_o | output | 1 | Transaction in progress |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 2 | Active-low chip selects |

## Verification
The bench builds the block with `HALF_CLKS`=3, `DATA_W`=8 and `LEN_W`=8. With three clocks per half period, a half that is off by one clock is measurable, and the clock edges where the master samples are well apart from the edges where the bench's register-file slave shifts. The 8-bit count makes the 255-byte burst reachable, and that burst's seven-bit register pointer wraps in the slave. Both phases are run against both targets, with and without stream stalls, and with address-only transactions.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_FETCH,
    ST_WDATA,
    ST_RDATA,
    ST_RWAIT,
    ST_END
  } xfer_state_e;

  localparam int unsigned NUM_TGT = 2;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned HALF_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (HALF_CLKS <= 1) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(HALF_CLKS);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CLKS - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (!en_i)             cnt_q <= '0;
        else if (cnt_q == CNT_LAST) cnt_q <= '0;
        else                        cnt_q <= cnt_q + CNT_W'(1);
      end

      assign tick_o = en_i && (cnt_q == CNT_LAST);
    end
  endgenerate
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              phase_i,
  input  logic              tick_i,
  input  logic              miso_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              active_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned HALVES = 2 * DATA_W;
  localparam int unsigned H_W    = $clog2(HALVES);
  localparam logic [H_W-1:0] H_LAST = H_W'(HALVES - 1);

  logic              active_q, done_q;
  logic [H_W-1:0]    half_q;
  logic [DATA_W-1:0] sh_q, rx_q;

  // even halves set up a bit, odd halves end with the sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      half_q   <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          half_q   <= '0;
          sh_q     <= tx_i;
        end
      end else if (tick_i) begin
        if (half_q[0]) begin
          rx_q <= {rx_q[DATA_W-2:0], miso_i};
          sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
        if (half_q == H_LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
        half_q <= half_q + H_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;
  assign sck_o    = active_q && (half_q[0] ^ phase_i);
  assign mosi_o   = active_q && sh_q[DATA_W-1];

  // R9
  sck_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(active_q) && active_q && !$past(tick_i) |-> $stable(sck_o));

  // R7
  msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !active_q |=> mosi_o == $past(tx_i[DATA_W-1]));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int unsigned HALF_CLKS = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LEN_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [DATA_W-2:0] cmd_reg_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              cmd_phase_i,
  input  logic              cmd_target_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] status_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [1:0]        cs_n_o
);
  xfer_state_e         state_q;
  logic                phase_q, write_q, go_q, rd_valid_q;
  logic [LEN_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   tx_q, rd_data_q, status_q;
  logic [NUM_TGT-1:0]  cs_n_q;
  logic                tick, sh_active, sh_done;
  logic [DATA_W-1:0]   sh_rx;
  logic                cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  spi_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sh_active),
    .tick_o (tick)
  );

  spi_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go_q),
    .phase_i  (phase_q),
    .tick_i   (tick),
    .miso_i   (miso_i),
    .tx_i     (tx_q),
    .active_o (sh_active),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .done_o   (sh_done),
    .rx_o     (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= 1'b0;
      write_q    <= 1'b0;
      go_q       <= 1'b0;
      rd_valid_q <= 1'b0;
      cnt_q      <= '0;
      tx_q       <= '0;
      rd_data_q  <= '0;
      status_q   <= '0;
      cs_n_q     <= '1;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          phase_q <= cmd_phase_i;
          write_q <= cmd_write_i;
          cnt_q   <= cmd_len_i;
          tx_q    <= {cmd_write_i, cmd_reg_i};
          go_q    <= 1'b1;
          cs_n_q  <= ~(NUM_TGT'(1) << cmd_target_i);
          state_q <= ST_ADDR;
        end
        ST_ADDR: if (sh_done) begin
          status_q <= sh_rx;
          if (cnt_zero)     state_q <= ST_END;
          else if (write_q) state_q <= ST_FETCH;
          else begin
            tx_q    <= '0;
            go_q    <= 1'b1;
            state_q <= ST_RDATA;
          end
        end
        ST_FETCH: if (wr_valid_i) begin
          tx_q    <= wr_data_i;
          go_q    <= 1'b1;
          cnt_q   <= cnt_q - LEN_W'(1);
          state_q <= ST_WDATA;
        end
        ST_WDATA: if (sh_done) state_q <= cnt_zero ? ST_END : ST_FETCH;
        ST_RDATA: if (sh_done) begin
          rd_data_q  <= sh_rx;
          rd_valid_q <= 1'b1;
          cnt_q      <= cnt_q - LEN_W'(1);
          state_q    <= ST_RWAIT;
        end
        ST_RWAIT: if (rd_ready_i) begin
          rd_valid_q <= 1'b0;
          if (cnt_zero) state_q <= ST_END;
          else begin
            tx_q    <= '0;
            go_q    <= 1'b1;
            state_q <= ST_RDATA;
          end
        end
        ST_END: begin
          cs_n_q  <= '1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign cmd_ready_o = !busy_o;
  assign wr_ready_o  = (state_q == ST_FETCH);
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign status_o    = status_q;
  assign cs_n_o      = cs_n_q;

  // R3
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  // R10
  busy_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (cs_n_o != '1));

  // R12
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(cs_n_o));

  // R1
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o && !mosi_o);

  // R6
  rd_mosi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RDATA |-> !mosi_o);

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && !sh_active);
endmodule

// File: tb/spi_reg_master_test.sv
module spi_reg_master_test;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0, cmd_phase = 0, cmd_target = 0;
  logic [6:0] cmd_reg = '0;
  logic [7:0] cmd_len = '0;
  logic wr_valid = 0, rd_ready = 0;
  logic [7:0] wr_data = '0;
  logic cmd_ready_o, wr_ready_o, rd_valid_o, busy_o, sck_o, mosi_o;
  logic [7:0] rd_data_o, status_o;
  logic [1:0] cs_n_o;
  logic slv_miso = 1'b0;

  always #2 clk = ~clk;

  spi_reg_master #(.HALF_CLKS(HALF), .DATA_W(8), .LEN_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready_o), .cmd_write_i(cmd_write),
    .cmd_reg_i(cmd_reg), .cmd_len_i(cmd_len), .cmd_phase_i(cmd_phase), .cmd_target_i(cmd_target),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready), .rd_data_o(rd_data_o),
    .status_o(status_o), .busy_o(busy_o), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(slv_miso), .cs_n_o(cs_n_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // register-file slave model, both targets share one file
  logic [7:0] sregs [128];
  logic [7:0] exp_mem [128];
  bit   slv_mode = 0;
  logic prev_sck = 0;
  logic [1:0] prev_cs = 2'b11;
  logic [7:0] s_tx = 0, s_rx = 0, s_next = 0, s_addr_byte = 0;
  logic [6:0] s_ptr = 0;
  bit   s_wr = 0, s_load = 0;
  int   s_bit = 0, s_byte = 0, s_edges = 0, txn_cnt = 0, mosi_bad = 0;

  task automatic slv_byte(input logic [7:0] b);
    if (s_byte == 0) begin
      s_addr_byte = b; s_wr = b[7]; s_ptr = b[6:0];
      s_next = s_wr ? 8'h00 : sregs[s_ptr];
    end else if (s_wr) begin
      sregs[s_ptr] = b; s_ptr = s_ptr + 7'd1; s_next = 8'h00;
    end else begin
      if (b != 8'h00) mosi_bad++;
      s_ptr = s_ptr + 7'd1; s_next = sregs[s_ptr];
    end
    s_byte++;
    s_load = 1;
  endtask

  always @(sck_o or cs_n_o) begin
    if ((prev_cs == 2'b11) && (cs_n_o != 2'b11)) begin
      txn_cnt++; s_bit = 0; s_byte = 0; s_edges = 0;
      s_next = (cs_n_o[1] == 1'b0) ? 8'hC3 : 8'h5A;
      if (!slv_mode) begin s_tx = s_next; slv_miso = s_tx[7]; s_load = 0; end
      else s_load = 1;
    end else if (cs_n_o != 2'b11 && sck_o && !prev_sck) begin
      s_edges++;
      if (!slv_mode) begin
        s_rx = {s_rx[6:0], mosi_o}; s_bit++;
        if (s_bit == 8) begin s_bit = 0; slv_byte(s_rx); end
      end else begin
        if (s_load) begin s_tx = s_next; s_load = 0; end
        else s_tx = s_tx << 1;
        slv_miso = s_tx[7];
      end
    end else if (cs_n_o != 2'b11 && !sck_o && prev_sck) begin
      if (!slv_mode) begin
        if (s_load) begin s_tx = s_next; s_load = 0; end
        else s_tx = s_tx << 1;
        slv_miso = s_tx[7];
      end else begin
        s_rx = {s_rx[6:0], mosi_o}; s_bit++;
        if (s_bit == 8) begin s_bit = 0; slv_byte(s_rx); end
      end
    end
    prev_sck = sck_o;
    prev_cs  = cs_n_o;
  end

  // line monitors
  bit exp_tgt = 0;
  int cs_bad = 0, sck_bad = 0, idle_bad = 0, rdy_bad = 0, hi_cnt = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n_o == 2'b00) cs_bad++;
    if (busy_o && cs_n_o[~exp_tgt] == 1'b0) cs_bad++;
    if (!busy_o && (sck_o || mosi_o || cs_n_o != 2'b11)) idle_bad++;
    if (busy_o && cmd_ready_o) rdy_bad++;
    if (sck_o) hi_cnt++;
    else if (hi_cnt != 0) begin
      if (hi_cnt != HALF) sck_bad++;
      hi_cnt = 0;
    end
  end

  task automatic run_txn(input bit wr, input bit ph, input bit tg, input bit stall,
                         input logic [6:0] addr, input int len, input bit poke, input int seed);
    int txn0, mb0, cb0, e0, bad;
    logic [7:0] d, rb;
    txn0 = txn_cnt; mb0 = mosi_bad; cb0 = cs_bad;
    slv_mode = ph; exp_tgt = tg;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_phase = ph; cmd_target = tg;
    cmd_reg = addr; cmd_len = 8'(len);
    while (!cmd_ready_o) @(negedge clk);
    @(negedge clk);
    if (poke) begin
      cmd_write = !wr; cmd_phase = !ph; cmd_target = !tg; cmd_reg = ~addr; cmd_len = 8'd9;
    end else cmd_valid = 0;
    check(busy_o && !cmd_ready_o, "R10 busy after accept", busy_o, 1);
    if (wr) begin
      for (int k = 0; k < len; k++) begin
        d = 8'(seed * 37 + k * 13 + 91);
        while (!wr_ready_o) @(negedge clk);
        if (stall) begin
          e0 = s_edges;
          repeat (20) @(negedge clk);
          check(s_edges == e0 && !sck_o && wr_ready_o, "R11 write stall", s_edges, e0);
        end
        wr_valid = 1; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
        exp_mem[7'(addr + 7'(k))] = d;
      end
    end else begin
      for (int k = 0; k < len; k++) begin
        while (!rd_valid_o) @(negedge clk);
        rb = rd_data_o;
        check(rb == exp_mem[7'(addr + 7'(k))], ph ? "R8 read byte phase 1" : "R7 read byte phase 0",
              rb, exp_mem[7'(addr + 7'(k))]);
        if (stall) begin
          e0 = s_edges;
          repeat (20) @(negedge clk);
          check(rd_valid_o && rd_data_o == rb && s_edges == e0, "R11 read stall", rd_data_o, rb);
        end
        rd_ready = 1;
        @(negedge clk);
        rd_ready = 0;
      end
    end
    while (busy_o) @(negedge clk);
    cmd_valid = 0;
    check(status_o == (tg ? 8'hC3 : 8'h5A), "R5 status byte", status_o, tg ? 8'hC3 : 8'h5A);
    check(s_addr_byte == {wr, addr}, "R2 address byte", s_addr_byte, {wr, addr});
    check(txn_cnt == txn0 + 1, "R10 one transaction per command", txn_cnt - txn0, 1);
    check(s_byte == len + 1, "R4 byte count", s_byte, len + 1);
    check(s_edges == 8 * (len + 1), "R7 sck edges", s_edges, 8 * (len + 1));
    check(cs_bad == cb0, "R3 chip select choice", cs_bad - cb0, 0);
    if (!wr) check(mosi_bad == mb0, "R6 mosi low in read", mosi_bad - mb0, 0);
    else begin
      bad = 0;
      for (int i = 0; i < 128; i++) if (sregs[i] != exp_mem[i]) bad++;
      check(bad == 0, "R4 burst write contents", bad, 0);
    end
  endtask

  // {wr, phase, target, stall, reg[6:0], len[7:0]}
  localparam logic [18:0] VECS [8] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 7'h10, 8'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 7'h10, 8'd1},
    {1'b1, 1'b1, 1'b1, 1'b1, 7'h7E, 8'd4},
    {1'b0, 1'b1, 1'b1, 1'b1, 7'h7E, 8'd4},
    {1'b1, 1'b1, 1'b0, 1'b0, 7'h20, 8'd3},
    {1'b0, 1'b0, 1'b1, 1'b0, 7'h20, 8'd3},
    {1'b0, 1'b1, 1'b0, 1'b0, 7'h05, 8'd0},
    {1'b1, 1'b0, 1'b1, 1'b0, 7'h33, 8'd0}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R4 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      sregs[i]   = 8'(i) ^ 8'h96;
      exp_mem[i] = 8'(i) ^ 8'h96;
    end
    repeat (3) @(negedge clk);
    check(cs_n_o == 2'b11 && !sck_o && !mosi_o && !busy_o, "R1 reset lines",
          {cs_n_o, sck_o, mosi_o, busy_o}, 5'b11000);
    check(cmd_ready_o && !wr_ready_o && !rd_valid_o, "R10 reset handshake",
          {cmd_ready_o, wr_ready_o, rd_valid_o}, 3'b100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++)
      run_txn(VECS[v][18], VECS[v][17], VECS[v][16], VECS[v][15], VECS[v][14:8],
              int'(VECS[v][7:0]), 1'b0, v);

    // longest burst, pointer wraps in the slave
    run_txn(1'b1, 1'b0, 1'b1, 1'b0, 7'h00, 255, 1'b0, 11);
    run_txn(1'b0, 1'b1, 1'b0, 1'b0, 7'h00, 255, 1'b0, 12);

    // R12: command inputs toggled while busy must be ignored
    run_txn(1'b0, 1'b0, 1'b0, 1'b0, 7'h41, 2, 1'b1, 13);
    repeat (4) @(negedge clk);
    check(!busy_o && cs_n_o == 2'b11, "R12 no second transaction", busy_o, 0);

    check(sck_bad == 0, "R9 sck half width", sck_bad, 0);
    check(idle_bad == 0, "R1 idle lines", idle_bad, 0);
    check(rdy_bad == 0, "R10 ready while busy", rdy_bad, 0);
    finish_run();
  end
endmodule